// File: doc/BRIEF.md
# Wiper Position Latch with Tap Decoder

This block keeps the volatile position of a digitally controlled potentiometer's wiper and turns it into a one-hot select across all taps of the resistor string. The command sequencer can change the position in three ways. It can write a value directly. It can copy one of the stored data register values into the latch. It can move the wiper by single steps up or down. The current position is always on an output port, so it can be read back or copied into a data register.

After reset the block copies data register slot zero into the latch. The values of the data registers come in on a flat bus from the nonvolatile storage, which is outside this block.

A settle timer models the time the analog wiper needs to respond. A small state machine starts it on every accepted change. It has three states:
- `ST_BOOT`: held while in reset. It moves unconditionally to `ST_WAIT` on the first clock edge after reset is released, and that edge performs the reload.
- `ST_IDLE`: no change is pending. It moves to `ST_WAIT` on any command.
- `ST_WAIT`: counting down. A new command restarts the count and stays in `ST_WAIT`. When the count reaches zero the state returns to `ST_IDLE`.

The settled flag is high for the single cycle in which `ST_WAIT` holds a zero count.

Top module: `wiper_pos_latch`

## Requirements
- R1: `tap_sel` bit n is high exactly when `pos_q` equals n. Bit 0 is the low terminal and bit 63 (position 0x3F) is the high terminal.
- R2: Exactly one bit of `tap_sel` is high in every cycle, including during reset.
- R3: When `wr_en` is high at a clock edge, `pos_q` takes `wr_data` after that edge. A direct write takes priority over a transfer and over a step in the same cycle.
- R4: When `xfer_en` is high at a clock edge and there is no write, `pos_q` takes data register slot `xfer_sel`. Slot k sits in bits [6k+5:6k] of `dreg_bank`. A transfer takes priority over a step in the same cycle.
- R5: On the first clock edge after `rst_n` rises, `pos_q` takes slot 0 of `dreg_bank`. Any write, transfer or step presented in that cycle is ignored.
- R6: When `step_en` is high and there is no load, the position moves one tap. It moves up when `step_up` is 1 and down when `step_up` is 0.
- R7: A step up at 63 leaves the position at 63. A step down at 0 leaves it at 0. The position never wraps.
- R8: `settle_pulse` is high for exactly one cycle. That cycle begins SETTLE_CYC clock edges after the edge that accepted a command or performed the reset reload. A newer command restarts the count, so no pulse is produced for the earlier one.
- R9: While `rst_n` is low, `pos_q` is 0, `tap_sel` equals 1 and `settle_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Direct write strobe |
| wr_data | input | POS_W | Value for a direct write |
| xfer_en | input | 1 | Transfer strobe, copies a data register into the latch |
| xfer_sel | input | SEL_W | Data register slot for a transfer |
| dreg_bank | input | NREG*POS_W | Data register contents, slot k at bits [k*POS_W +: POS_W] |
| step_en | input | 1 | Single-step strobe |
| step_up | input | 1 | Step direction: 1 moves toward the high end, 0 toward the low end |
| pos_q | output | POS_W | Current wiper position |
| tap_sel | output | 2**POS_W | One-hot tap select |
| settle_pulse | output | 1 | One-cycle flag that the wiper has settled |

## Verification
A command driven in one cycle changes `pos_q` and `tap_sel` on the very next rising edge. The bench drives its inputs on falling edges and reads both outputs on the falling edge that follows the accepting rising edge. The settle flag is due SETTLE_CYC rising edges after that same accepting edge. The bench counts falling edges from the point where it reads the position, and checks that the flag is low at every earlier count, high at exactly that count, and low again one count later. In the restart case the count is taken from the second command. That sample would still find the flag high if the first command's pulse had not been cancelled.

// File: rtl/wpl_pkg.sv
package wpl_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_IDLE = 2'd1,
        ST_WAIT = 2'd2
    } settle_st_e;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_WRITE = 2'd1,
        SRC_XFER  = 2'd2,
        SRC_STEP  = 2'd3
    } pos_src_e;

endpackage

// File: rtl/wpl_pos_next.sv
module wpl_pos_next
    import wpl_pkg::*;
#(
    parameter int POS_W = 6,
    parameter int NREG  = 4,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [POS_W-1:0]      cur_pos,
    input  logic                  boot,
    input  logic                  wr_en,
    input  logic [POS_W-1:0]      wr_data,
    input  logic                  xfer_en,
    input  logic [SEL_W-1:0]      xfer_sel,
    input  logic [NREG*POS_W-1:0] dreg_bank,
    input  logic                  step_en,
    input  logic                  step_up,
    output logic [POS_W-1:0]      nxt_pos,
    output logic                  change
);

    localparam logic [POS_W-1:0] POS_MAX = '1;
    localparam logic [POS_W-1:0] POS_MIN = '0;

    logic [POS_W-1:0] slot [NREG];
    pos_src_e         src;
    logic [POS_W-1:0] stepped;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        assign slot[g] = dreg_bank[g*POS_W +: POS_W];
    end

    // Priority among the sources: write, then transfer, then step
    always_comb begin
        if (wr_en)        src = SRC_WRITE;
        else if (xfer_en) src = SRC_XFER;
        else if (step_en) src = SRC_STEP;
        else              src = SRC_HOLD;
    end

    // A step saturates at both ends of the string
    always_comb begin
        if (step_up) stepped = (cur_pos == POS_MAX) ? cur_pos : cur_pos + 1'b1;
        else         stepped = (cur_pos == POS_MIN) ? cur_pos : cur_pos - 1'b1;
    end

    always_comb begin
        if (boot) begin
            nxt_pos = slot[0];
        end else begin
            unique case (src)
                SRC_WRITE: nxt_pos = wr_data;
                SRC_XFER:  nxt_pos = slot[xfer_sel];
                SRC_STEP:  nxt_pos = stepped;
                default:   nxt_pos = cur_pos;
            endcase
        end
    end

    assign change = boot || (src != SRC_HOLD);

endmodule

// File: rtl/wpl_settle_fsm.sv
module wpl_settle_fsm
    import wpl_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    localparam int CW = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic boot_o,
    output logic settle_o
);

    localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYC);

    settle_st_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_BOOT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_BOOT: begin
                st_d  = ST_WAIT;
                cnt_d = CNT_LOAD;
            end
            ST_IDLE: begin
                if (evt) begin
                    st_d  = ST_WAIT;
                    cnt_d = CNT_LOAD;
                end
            end
            ST_WAIT: begin
                if (evt) begin
                    cnt_d = CNT_LOAD;
                end else if (cnt_q == '0) begin
                    st_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                st_d  = ST_BOOT;
                cnt_d = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        boot_o   = (st_q == ST_BOOT);
        settle_o = (st_q == ST_WAIT) && (cnt_q == '0);
    end

    // R8: the flag never lasts two cycles
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        settle_o |=> !settle_o);

    // R8: a command restarts the wait, so no flag on the following cycle
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !settle_o);

    // R5: the reload state is left after one edge and never re-entered
    p_boot_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        boot_o |=> !boot_o);

endmodule

// File: rtl/wpl_tap_decoder.sv
module wpl_tap_decoder #(
    parameter int POS_W = 6,
    localparam int TAPS = 1 << POS_W
) (
    input  logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  tap_sel
);

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign tap_sel[g] = (pos == POS_W'(g));
    end

endmodule

// File: rtl/wiper_pos_latch.sv
module wiper_pos_latch
    import wpl_pkg::*;
#(
    parameter int POS_W      = 6,
    parameter int NREG       = 4,
    parameter int SETTLE_CYC = 4,
    localparam int TAPS  = 1 << POS_W,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [POS_W-1:0]      wr_data,
    input  logic                  xfer_en,
    input  logic [SEL_W-1:0]      xfer_sel,
    input  logic [NREG*POS_W-1:0] dreg_bank,
    input  logic                  step_en,
    input  logic                  step_up,
    output logic [POS_W-1:0]      pos_q,
    output logic [TAPS-1:0]       tap_sel,
    output logic                  settle_pulse
);

    logic [POS_W-1:0] nxt_pos;
    logic             change;
    logic             boot;

    wpl_settle_fsm #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (change),
        .boot_o   (boot),
        .settle_o (settle_pulse)
    );

    wpl_pos_next #(
        .POS_W (POS_W),
        .NREG  (NREG)
    ) u_next (
        .cur_pos   (pos_q),
        .boot      (boot),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .xfer_en   (xfer_en),
        .xfer_sel  (xfer_sel),
        .dreg_bank (dreg_bank),
        .step_en   (step_en),
        .step_up   (step_up),
        .nxt_pos   (nxt_pos),
        .change    (change)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= nxt_pos;
    end

    wpl_tap_decoder #(
        .POS_W (POS_W)
    ) u_dec (
        .pos     (pos_q),
        .tap_sel (tap_sel)
    );

    // R2: exactly one tap is driven
    p_one_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1);

    // R1: the active tap sits at the position index
    p_tap_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel[pos_q] == 1'b1);

    // R3: a direct write lands on the next edge
    p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !boot) |=> (pos_q == $past(wr_data)));

    // R4: a transfer copies the selected slot
    p_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && !wr_en && !boot)
        |=> (pos_q == $past(dreg_bank[xfer_sel*POS_W +: POS_W])));

    // R5: the reset reload takes slot zero
    p_boot_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        boot |=> (pos_q == $past(dreg_bank[POS_W-1:0])));

    // R6: a step up below the top moves by one
    p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && !wr_en && !xfer_en && !boot && (pos_q != '1))
        |=> (pos_q == $past(pos_q) + 1'b1));

    // R6: a step down above the bottom moves by one
    p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && !wr_en && !xfer_en && !boot && (pos_q != '0))
        |=> (pos_q == $past(pos_q) - 1'b1));

    // R7: saturation at the top
    p_sat_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && !wr_en && !xfer_en && !boot && (pos_q == '1))
        |=> (pos_q == '1));

    // R7: saturation at the bottom
    p_sat_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && !wr_en && !xfer_en && !boot && (pos_q == '0))
        |=> (pos_q == '0));

endmodule

// File: tb/sim_wiper_pos_latch.sv
module sim_wiper_pos_latch;

    localparam int CLK_P  = 10;
    localparam int POS_W  = 6;
    localparam int NREG   = 4;
    localparam int SETTLE = 4;
    localparam int TAPS   = 1 << POS_W;

    // Row layout: [17] write, [16:11] write value, [10] transfer,
    // [9:8] slot, [7] step, [6] up, [5:0] expected position
    localparam int NVEC = 15;
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 6'd0,  1'b0, 2'd0, 1'b1, 1'b1, 6'd22}, // R6 up
        {1'b0, 6'd0,  1'b0, 2'd0, 1'b1, 1'b0, 6'd21}, // R6 down
        {1'b1, 6'd62, 1'b0, 2'd0, 1'b0, 1'b0, 6'd62}, // R3 write
        {1'b0, 6'd0,  1'b0, 2'd0, 1'b1, 1'b1, 6'd63}, // R6 up to top
        {1'b0, 6'd0,  1'b0, 2'd0, 1'b1, 1'b1, 6'd63}, // R7 top saturates
        {1'b0, 6'd0,  1'b1, 2'd3, 1'b0, 1'b0, 6'd2},  // R4 slot 3
        {1'b0, 6'd0,  1'b0, 2'd0, 1'b1, 1'b0, 6'd1},  // R6 down
        {1'b0, 6'd0,  1'b0, 2'd0, 1'b1, 1'b0, 6'd0},  // R6 down to bottom
        {1'b0, 6'd0,  1'b0, 2'd0, 1'b1, 1'b0, 6'd0},  // R7 bottom saturates
        {1'b0, 6'd0,  1'b1, 2'd1, 1'b0, 1'b0, 6'd40}, // R4 slot 1
        {1'b1, 6'd5,  1'b1, 2'd2, 1'b0, 1'b0, 6'd5},  // R3 write beats transfer
        {1'b0, 6'd0,  1'b1, 2'd2, 1'b1, 1'b1, 6'd63}, // R4 transfer beats step
        {1'b1, 6'd10, 1'b0, 2'd0, 1'b1, 1'b0, 6'd10}, // R3 write beats step
        {1'b0, 6'd0,  1'b1, 2'd0, 1'b0, 1'b0, 6'd21}, // R4 slot 0
        {1'b0, 6'd0,  1'b0, 2'd0, 1'b0, 1'b0, 6'd21}  // hold
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic [POS_W-1:0]      wr_data = '0;
    logic                  xfer_en = 1'b0;
    logic [1:0]            xfer_sel = '0;
    logic [NREG*POS_W-1:0] dreg_bank = {6'd2, 6'd63, 6'd40, 6'd21};
    logic                  step_en = 1'b0;
    logic                  step_up = 1'b0;
    logic [POS_W-1:0]      pos_q;
    logic [TAPS-1:0]       tap_sel;
    logic                  settle_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wiper_pos_latch #(
        .POS_W      (POS_W),
        .NREG       (NREG),
        .SETTLE_CYC (SETTLE)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .xfer_en      (xfer_en),
        .xfer_sel     (xfer_sel),
        .dreg_bank    (dreg_bank),
        .step_en      (step_en),
        .step_up      (step_up),
        .pos_q        (pos_q),
        .tap_sel      (tap_sel),
        .settle_pulse (settle_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_pos(input string req, input int exp);
        chk(req, 64'(pos_q), 64'(exp));
        chk(req, tap_sel, 64'(1) << exp);
    endtask

    // Drive at a falling edge, return at the next falling edge with inputs cleared
    task automatic cmd(input logic w, input logic [5:0] wd, input logic x,
                       input logic [1:0] xs, input logic s, input logic u);
        wr_en = w; wr_data = wd; xfer_en = x; xfer_sel = xs; step_en = s; step_up = u;
        @(negedge clk);
        wr_en = 1'b0; xfer_en = 1'b0; step_en = 1'b0;
    endtask

    // Checks the flag over SETTLE+1 falling edges after the accepting edge
    task automatic chk_settle(input string req);
        for (int i = 1; i <= SETTLE + 1; i++) begin
            @(negedge clk);
            chk(req, 64'(settle_pulse), 64'(i == SETTLE));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset pos", 64'(pos_q), 64'd0);
        chk("R9 reset tap", tap_sel, 64'd1);
        chk("R9 reset settle", 64'(settle_pulse), 64'd0);
        chk("R2 one tap in reset", 64'($countones(tap_sel)), 64'd1);

        // R5 reload from slot 0; a write in the same cycle is ignored
        rst_n = 1'b1;
        cmd(1'b1, 6'd50, 1'b0, 2'd0, 1'b1, 1'b1);
        chk_pos("R5 reload slot 0, write ignored", 21);
        chk_settle("R8 settle after reload");

        // Vector table: R1 R3 R4 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            cmd(VEC[v][17], VEC[v][16:11], VEC[v][10], VEC[v][9:8], VEC[v][7], VEC[v][6]);
            chk_pos($sformatf("R1 R3 R4 R6 R7 vector %0d", v), int'(VEC[v][5:0]));
            chk("R2 one tap", 64'($countones(tap_sel)), 64'd1);
        end
        repeat (SETTLE + 2) @(negedge clk);

        // R8 settle timing after a single step
        cmd(1'b0, 6'd0, 1'b0, 2'd0, 1'b1, 1'b1);
        chk_pos("R6 step before settle", 22);
        chk_settle("R8 settle after step");

        // R8 restart: second command two edges after the first
        cmd(1'b1, 6'd30, 1'b0, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        cmd(1'b0, 6'd0, 1'b1, 2'd1, 1'b0, 1'b0);
        chk_pos("R4 transfer in restart", 40);
        chk_settle("R8 restart");

        // R9 reset in mid-run with a write pending
        wr_en = 1'b1; wr_data = 6'd33; rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid reset pos", 64'(pos_q), 64'd0);
        chk("R9 mid reset tap", tap_sel, 64'd1);
        chk("R9 mid reset settle", 64'(settle_pulse), 64'd0);
        wr_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cmd(1'b0, 6'd0, 1'b1, 2'd2, 1'b1, 1'b0);
        chk_pos("R5 reload after reset, transfer ignored", 21);
        chk_settle("R8 settle after second reload");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule